// File: doc/BRIEF.md
# Serial Register Bank with Pipelined Readback

This block is a serial-peripheral slave that gives a host access to a small set of control and status bytes. Each access is two bytes long. The first is a command byte: bit 7 selects write (1) or read (0), bits 6:5 are ignored, and bits 4:0 give the address. The second is a data byte. Addresses below `NUM_CTRL` (0 to 3 by default) hold read/write control bytes, which drive `ctrl_o`. The next `NUM_STAT` addresses (4 to 7) hold read-only copies of `status_i`.

Readback is pipelined by one command. During each command byte, the slave shifts out the byte that the previous command produced. That byte is the addressed contents for a read, and the displaced old contents for a write. A write takes effect only when chip select is released. Status copies are refreshed from `status_i` on every system clock while chip select is high, and they are frozen while it is low.

All three serial pins are brought into the system clock domain through synchronisers and sampled there. SCLK must therefore run at no more than a quarter of `clk`. The serial link uses mode 0: DI is sampled on the rising SCLK edge, DO changes on the falling edge, and bits go MSB first. One chip-select window may carry several command/data pairs.

Top module: `spi_regbank`

## Requirements
- R1: A command byte with bit 7 = 1 is a write and with bit 7 = 0 is a read. Bits 4:0 are the address and bits 6:5 have no effect. Bytes are shifted MSB first, and SDI is sampled on rising SCLK.
- R2: `spi_sdo_oe` is 0 while chip select is high and 1 while it is low. SDO changes only after falling SCLK edges or the start of a frame.
- R3: After reset, every `ctrl_o` byte is 0x00 and the first command byte shifts out 0x00.
- R4: During each command byte, SDO carries the byte produced by the preceding command, which may belong to the previous frame.
- R5: During the data byte of a write, SDO returns the old contents of the addressed register.
- R6: A write changes `ctrl_o` only after chip select rises. A read of the same register in the next frame returns the old value during its command byte and the new value after it.
- R7: Status copies follow `status_i` only while chip select is high. A read made while it is low returns the value captured before it fell.
- R8: Writes to status addresses (4 to 7) leave every register unchanged. Reads of addresses with no register (8 and above) return 0x00.
- R9: A frame that ends inside a byte, or between a command byte and its data byte, commits no write and leaves the byte returned by the next command byte unchanged.
- R10: Within one frame, each command byte returns the result of the pair before it. If a frame holds several writes, only the last of them is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sdi | input | 1 | Serial data from host |
| spi_sdo | output | 1 | Serial data to host, 0 when not driven |
| spi_sdo_oe | output | 1 | Output enable for the SDO pad |
| status_i | input | NUM_STAT*8 | Status bytes, byte k at address NUM_CTRL+k |
| ctrl_o | output | NUM_CTRL*8 | Control bytes, byte k at address k |

## Verification
On every cycle, the embedded properties check the following. Control and status bytes stay fixed while chip select is low. A pending write never targets a status address. An aborted frame leaves the staged readback byte untouched. The transmit register moves only on falling SCLK edges or at the start of a frame. The bench scenarios are needed for the value-level behaviour that spans frames: the one-command lag, the echo of old data on writes, the stale status byte after chip select falls, the last-write-wins rule inside a frame, and the checks that reserved command bits and missing addresses have no effect.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 5;
  localparam int WR_BIT = 7;

  typedef enum logic {
    PH_CMD  = 1'b0,
    PH_DATA = 1'b1
  } phase_e;
endpackage

// File: rtl/spi_rb_sync.sv
// Multi-stage synchroniser for a group of asynchronous pins. Exposes the
// settled level and the one-cycle-older copy so edges can be derived.
module spi_rb_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] prev_o
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0][W-1:0] stage_q;
  logic [DEPTH-1:0][W-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[DEPTH-2:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= {DEPTH{RST_VAL}};
    else        stage_q <= stage_d;
  end

  assign lvl_o  = stage_q[STAGES-1];
  assign prev_o = stage_q[STAGES];
endmodule

// File: rtl/spi_rb_shift.sv
// Bit-level shifter: receive on rising SCLK, transmit on falling SCLK.
module spi_rb_shift
  import spi_rb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              sel_start,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              sdi,
  input  logic [BYTE_W-1:0] frame_byte,
  input  logic [BYTE_W-1:0] next_byte,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              byte_done,
  output logic              mid_byte,
  output logic              sdo_bit
);
  localparam int                CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0]  LAST  = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  bit_q, bit_d;
  logic [BYTE_W-1:0] rx_q, rx_d;
  logic [BYTE_W-1:0] tx_q, tx_d;

  assign rx_byte   = {rx_q[BYTE_W-2:0], sdi};
  assign byte_done = sel && sclk_rise && (bit_q == LAST);
  assign mid_byte  = (bit_q != '0);
  assign sdo_bit   = tx_q[BYTE_W-1];

  always_comb begin
    bit_d = bit_q;
    rx_d  = rx_q;
    tx_d  = tx_q;
    if (sel_start) begin
      bit_d = '0;
      tx_d  = frame_byte;
    end else if (sel && sclk_rise) begin
      rx_d  = rx_byte;
      bit_d = bit_q + 1'b1;
    end else if (sel && sclk_fall) begin
      // counter wrapped to zero: a whole byte went by, start the next one
      tx_d = (bit_q == '0) ? next_byte : {tx_q[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0;
      rx_q  <= '0;
      tx_q  <= '0;
    end else begin
      bit_q <= bit_d;
      rx_q  <= rx_d;
      tx_q  <= tx_d;
    end
  end

  AST_TX_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_fall && !sel_start) |=> $stable(tx_q)); // R2
endmodule

// File: rtl/spi_rb_bank.sv
// Control bytes (written on commit) and status copies (sampled while idle).
module spi_rb_bank
  import spi_rb_pkg::*;
#(
  parameter int NUM_CTRL = 4,
  parameter int NUM_STAT = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_idle,
  input  logic                       commit_en,
  input  logic [ADDR_W-1:0]          commit_addr,
  input  logic [BYTE_W-1:0]          commit_data,
  input  logic [NUM_STAT*BYTE_W-1:0] status_i,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [BYTE_W-1:0]          rd_data,
  output logic [NUM_CTRL*BYTE_W-1:0] ctrl_o
);
  logic [NUM_CTRL-1:0][BYTE_W-1:0] ctrl_q, ctrl_d;
  logic [NUM_STAT-1:0][BYTE_W-1:0] stat_q, stat_d;

  for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
    assign ctrl_d[g] = (commit_en && commit_addr == ADDR_W'(g)) ? commit_data : ctrl_q[g];
  end

  for (genvar s = 0; s < NUM_STAT; s++) begin : g_stat
    assign stat_d[s] = cs_idle ? status_i[s*BYTE_W +: BYTE_W] : stat_q[s];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      stat_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      stat_q <= stat_d;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_CTRL; i++)
      if (rd_addr == ADDR_W'(i)) rd_data = ctrl_q[i];
    for (int i = 0; i < NUM_STAT; i++)
      if (rd_addr == ADDR_W'(NUM_CTRL + i)) rd_data = stat_q[i];
  end

  assign ctrl_o = ctrl_q;

  AST_CTRL_HELD_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_idle |=> $stable(ctrl_q)); // R6
  AST_STATUS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_idle |=> $stable(stat_q)); // R7
endmodule

// File: rtl/spi_regbank.sv
module spi_regbank
  import spi_rb_pkg::*;
#(
  parameter int NUM_CTRL    = 4,
  parameter int NUM_STAT    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       spi_sclk,
  input  logic                       spi_cs_n,
  input  logic                       spi_sdi,
  output logic                       spi_sdo,
  output logic                       spi_sdo_oe,
  input  logic [NUM_STAT*BYTE_W-1:0] status_i,
  output logic [NUM_CTRL*BYTE_W-1:0] ctrl_o
);
  localparam int PIN_W  = 3;
  localparam int P_CS   = 2;
  localparam int P_SCLK = 1;
  localparam int P_SDI  = 0;
  localparam logic [ADDR_W-1:0] CTRL_LIMIT = ADDR_W'(NUM_CTRL);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign srst_n = rst_pipe_q[1];

  logic [PIN_W-1:0] pin_lvl, pin_prev;
  spi_rb_sync #(
    .W       (PIN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk    (clk),
    .rst_n  (srst_n),
    .pin_i  ({spi_cs_n, spi_sclk, spi_sdi}),
    .lvl_o  (pin_lvl),
    .prev_o (pin_prev)
  );

  logic sel, sel_start, sel_end, sclk_rise, sclk_fall, sdi_s;
  assign sel       = ~pin_lvl[P_CS];
  assign sel_start = ~pin_lvl[P_CS] &  pin_prev[P_CS];
  assign sel_end   =  pin_lvl[P_CS] & ~pin_prev[P_CS];
  assign sclk_rise =  pin_lvl[P_SCLK] & ~pin_prev[P_SCLK];
  assign sclk_fall = ~pin_lvl[P_SCLK] &  pin_prev[P_SCLK];
  // older copy of DI: it was set up well before the rising edge
  assign sdi_s     = pin_prev[P_SDI];

  phase_e            phase_q, phase_d;
  logic              cmd_wr_q, cmd_wr_d;
  logic [ADDR_W-1:0] cmd_addr_q, cmd_addr_d;
  logic [BYTE_W-1:0] tx_next_q, tx_next_d;
  logic [BYTE_W-1:0] out_stage_q, out_stage_d;
  logic [BYTE_W-1:0] out_keep_q, out_keep_d;
  logic              pend_valid_q, pend_valid_d;
  logic [ADDR_W-1:0] pend_addr_q, pend_addr_d;
  logic [BYTE_W-1:0] pend_data_q, pend_data_d;

  logic [BYTE_W-1:0] rx_byte, rd_data, next_byte;
  logic              byte_done, mid_byte, sdo_bit;
  logic              frame_clean, commit_en;

  assign next_byte   = (phase_q == PH_DATA) ? tx_next_q : out_stage_q;
  assign frame_clean = (phase_q == PH_CMD) && !mid_byte;
  assign commit_en   = sel_end && frame_clean && pend_valid_q;

  spi_rb_shift u_shift (
    .clk        (clk),
    .rst_n      (srst_n),
    .sel        (sel),
    .sel_start  (sel_start),
    .sclk_rise  (sclk_rise),
    .sclk_fall  (sclk_fall),
    .sdi        (sdi_s),
    .frame_byte (out_keep_q),
    .next_byte  (next_byte),
    .rx_byte    (rx_byte),
    .byte_done  (byte_done),
    .mid_byte   (mid_byte),
    .sdo_bit    (sdo_bit)
  );

  spi_rb_bank #(
    .NUM_CTRL (NUM_CTRL),
    .NUM_STAT (NUM_STAT)
  ) u_bank (
    .clk         (clk),
    .rst_n       (srst_n),
    .cs_idle     (pin_lvl[P_CS]),
    .commit_en   (commit_en),
    .commit_addr (pend_addr_q),
    .commit_data (pend_data_q),
    .status_i    (status_i),
    .rd_addr     (rx_byte[ADDR_W-1:0]),
    .rd_data     (rd_data),
    .ctrl_o      (ctrl_o)
  );

  always_comb begin
    phase_d      = phase_q;
    cmd_wr_d     = cmd_wr_q;
    cmd_addr_d   = cmd_addr_q;
    tx_next_d    = tx_next_q;
    out_stage_d  = out_stage_q;
    out_keep_d   = out_keep_q;
    pend_valid_d = pend_valid_q;
    pend_addr_d  = pend_addr_q;
    pend_data_d  = pend_data_q;
    if (sel_start) begin
      phase_d      = PH_CMD;
      out_stage_d  = out_keep_q;
      pend_valid_d = 1'b0;
    end else if (sel_end) begin
      phase_d      = PH_CMD;
      pend_valid_d = 1'b0;
      if (frame_clean) out_keep_d = out_stage_q;
    end else if (byte_done) begin
      if (phase_q == PH_CMD) begin
        phase_d    = PH_DATA;
        cmd_wr_d   = rx_byte[WR_BIT];
        cmd_addr_d = rx_byte[ADDR_W-1:0];
        tx_next_d  = rd_data;
      end else begin
        phase_d     = PH_CMD;
        out_stage_d = tx_next_q;
        if (cmd_wr_q && (cmd_addr_q < CTRL_LIMIT)) begin
          pend_valid_d = 1'b1;
          pend_addr_d  = cmd_addr_q;
          pend_data_d  = rx_byte;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      phase_q      <= PH_CMD;
      cmd_wr_q     <= 1'b0;
      cmd_addr_q   <= '0;
      tx_next_q    <= '0;
      out_stage_q  <= '0;
      out_keep_q   <= '0;
      pend_valid_q <= 1'b0;
      pend_addr_q  <= '0;
      pend_data_q  <= '0;
    end else begin
      phase_q      <= phase_d;
      cmd_wr_q     <= cmd_wr_d;
      cmd_addr_q   <= cmd_addr_d;
      tx_next_q    <= tx_next_d;
      out_stage_q  <= out_stage_d;
      out_keep_q   <= out_keep_d;
      pend_valid_q <= pend_valid_d;
      pend_addr_q  <= pend_addr_d;
      pend_data_q  <= pend_data_d;
    end
  end

  assign spi_sdo_oe = sel;
  assign spi_sdo    = sel & sdo_bit;

  AST_PENDING_WRITE_IS_CTRL: assert property (@(posedge clk) disable iff (!srst_n)
    pend_valid_q |-> (pend_addr_q < CTRL_LIMIT)); // R8
  AST_ABORTED_FRAME_KEEPS_OUT: assert property (@(posedge clk) disable iff (!srst_n)
    (sel_end && !frame_clean) |=> $stable(out_keep_q)); // R9
endmodule

// File: tb/spi_regbank_test.sv
module spi_regbank_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        spi_sclk, spi_cs_n, spi_sdi;
  logic        spi_sdo, spi_sdo_oe;
  logic [31:0] status_i;
  logic [31:0] ctrl_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  spi_regbank uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_sclk   (spi_sclk),
    .spi_cs_n   (spi_cs_n),
    .spi_sdi    (spi_sdi),
    .spi_sdo    (spi_sdo),
    .spi_sdo_oe (spi_sdo_oe),
    .status_i   (status_i),
    .ctrl_o     (ctrl_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_begin();
    spi_cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic cs_end();
    wait_clk(HALF);
    spi_cs_n = 1'b1;
    wait_clk(2*HALF);
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < nbits; i++) begin
      spi_sdi = tx[7-i];
      wait_clk(HALF);
      rx = {rx[6:0], spi_sdo};
      spi_sclk = 1'b1;
      wait_clk(HALF);
      spi_sclk = 1'b0;
    end
  endtask

  task automatic pair(input logic [7:0] cmd, input logic [7:0] dat,
                      output logic [7:0] r_cmd, output logic [7:0] r_dat);
    xfer(cmd, 8, r_cmd);
    xfer(dat, 8, r_dat);
  endtask

  task automatic test_reset();
    logic [7:0] a, b;
    chk("R3 ctrl after reset", ctrl_o, 32'h0);
    chk("R2 oe idle", {31'b0, spi_sdo_oe}, 32'h0);
    cs_begin();
    chk("R2 oe selected", {31'b0, spi_sdo_oe}, 32'h1);
    pair(8'h00, 8'h00, a, b);
    chk("R3 first command byte", {24'b0, a}, 32'h00);
    chk("R1 read ctrl0", {24'b0, b}, 32'h00);
    cs_end();
    chk("R2 oe after frame", {31'b0, spi_sdo_oe}, 32'h0);
  endtask

  task automatic test_write_echo();
    logic [7:0] a, b;
    cs_begin();
    pair(8'h81, 8'hA5, a, b);
    chk("R4 cmd byte carries previous", {24'b0, a}, 32'h00);
    chk("R5 echo old ctrl1", {24'b0, b}, 32'h00);
    chk("R6 no commit before CS rise", ctrl_o, 32'h0);
    cs_end();
    chk("R6 commit on CS rise", ctrl_o, 32'h0000A500);
    cs_begin();
    pair(8'h81, 8'h3C, a, b);
    chk("R5 echo old ctrl1 A5", {24'b0, b}, 32'h000000A5);
    cs_end();
    chk("R6 second commit", ctrl_o, 32'h00003C00);
  endtask

  task automatic test_read_after_write();
    logic [7:0] a, b;
    cs_begin();
    pair(8'h01, 8'h00, a, b);
    chk("R6 old value once more", {24'b0, a}, 32'h000000A5);
    chk("R6 new value after read cmd", {24'b0, b}, 32'h0000003C);
    cs_end();
    cs_begin();
    pair(8'h60, 8'hFF, a, b);
    chk("R4 pipelined read result", {24'b0, a}, 32'h0000003C);
    chk("R1 reserved bits ignored, read ctrl0", {24'b0, b}, 32'h00);
    cs_end();
    chk("R1 read with data FF wrote nothing", ctrl_o, 32'h00003C00);
  endtask

  task automatic test_status_freeze();
    logic [7:0] a, b;
    cs_begin();
    status_i[7:0] = 8'h5A;
    wait_clk(4);
    pair(8'h04, 8'h00, a, b);
    chk("R7 stale status while selected", {24'b0, b}, 32'h00000011);
    cs_end();
    cs_begin();
    pair(8'h04, 8'h00, a, b);
    chk("R4 status pipelined", {24'b0, a}, 32'h00000011);
    chk("R7 status refreshed while idle", {24'b0, b}, 32'h0000005A);
    cs_end();
  endtask

  task automatic test_status_write_ignored();
    logic [7:0] a, b;
    cs_begin();
    pair(8'h85, 8'hFF, a, b);
    chk("R5 echo status5", {24'b0, b}, 32'h00000022);
    cs_end();
    chk("R8 ctrl untouched", ctrl_o, 32'h00003C00);
    cs_begin();
    pair(8'h05, 8'h00, a, b);
    chk("R8 status5 kept", {24'b0, b}, 32'h00000022);
    pair(8'h09, 8'h00, a, b);
    chk("R8 unmapped reads zero", {24'b0, b}, 32'h00);
    cs_end();
  endtask

  task automatic test_partial_frame();
    logic [7:0] a, b;
    cs_begin();
    pair(8'h01, 8'h00, a, b);
    cs_end();
    cs_begin();
    xfer(8'h80, 8, a);
    chk("R9 cmd byte before abort", {24'b0, a}, 32'h0000003C);
    xfer(8'h77, 4, b);
    cs_end();
    chk("R9 aborted write not committed", ctrl_o, 32'h00003C00);
    cs_begin();
    xfer(8'h82, 3, a);
    cs_end();
    cs_begin();
    pair(8'h00, 8'h00, a, b);
    chk("R9 readback undisturbed", {24'b0, a}, 32'h0000003C);
    chk("R9 ctrl0 still zero", {24'b0, b}, 32'h00);
    cs_end();
  endtask

  task automatic test_multi_pair();
    logic [7:0] a, b;
    cs_begin();
    pair(8'h01, 8'h00, a, b);
    chk("R10 first pair read", {24'b0, b}, 32'h0000003C);
    pair(8'h82, 8'h12, a, b);
    chk("R10 pipelined within frame", {24'b0, a}, 32'h0000003C);
    pair(8'h83, 8'h34, a, b);
    chk("R10 echo old ctrl2 on next cmd", {24'b0, a}, 32'h00);
    cs_end();
    chk("R10 only last write commits", ctrl_o, 32'h34003C00);
    cs_begin();
    pair(8'h03, 8'h00, a, b);
    chk("R10 ctrl3 readback", {24'b0, b}, 32'h00000034);
    cs_end();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    spi_sclk = 1'b0;
    spi_cs_n = 1'b1;
    spi_sdi  = 1'b0;
    status_i = 32'h44332211;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    test_reset();
    test_write_echo();
    test_read_after_write();
    test_status_freeze();
    test_status_write_ignored();
    test_partial_frame();
    test_multi_pair();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule